// File: doc/BRIEF.md
# Receiver Enable Training Sequencer

This block runs one hardware-assisted DQS receiver-enable training pass on one rank of a DDR3 channel. A start request names a DIMM. The block checks that auto refresh and ZQ calibration are already off. It then latches the DIMM, derives the chip select of the rank under training, and drives the DIMM select toward the PHY.

The pass runs in a fixed order:
1. A handshake asks the delay calculator to program the seed delays of every byte lane.
2. The block raises the training-enable control.
3. It issues three back-to-back 64-byte read requests to one fixed test address.
4. After the last read is accepted it waits 200 clocks.
5. It drops training-enable.
6. It asks the calculator for the final per-lane receiver-enable delays. These come back as a stream, one delay per lane, and the block keeps the largest.
7. It offers that maximum to the max-latency programming step.

A one-cycle done pulse closes the pass.

Three interfaces carry data, and all of them are valid/ready:
- Read requests (`rd_valid`/`rd_ready`). Under back-pressure `rd_valid`, `rd_addr` and `rd_len` hold until `rd_ready` is seen.
- Lane results (`lane_valid`/`lane_ready`). The block is ready on every cycle of the compute phase, so it never applies back-pressure there.
- The maximum-latency output (`ml_valid`/`ml_ready`). `ml_valid` and `ml_dly` hold until `ml_ready` is seen.

The seed and compute requests are plain level requests. The seed request ends on `seed_ack`, and the compute request ends on the lane marked last.

Top module: `rxen_train_seq`

## Requirements
- R1: A start is accepted only when the block is idle and both `refresh_off` and `zqcal_off` are high. `busy` goes high in the cycle after an accepted start. A start that is refused leaves `busy` low and causes no other output change.
- R2: At accept, the block latches `dimm_idx`. While the pass runs, `dimm_sel` equals the latched index and `cs_num` equals the index times two, so that `cs_num` shifted right by one equals `dimm_sel`.
- R3: `seed_req` is high from the cycle after accept until the cycle in which `seed_ack` is sampled high. `trn_en` stays low throughout that time.
- R4: `trn_en` rises in the cycle after the seed handshake. While `trn_en` is high, exactly three read handshakes take place. Each read request is held until it is acknowledged before the next one is presented.
- R5: Every read request carries `rd_addr` = 0x200000 (bit 21 set, in 64 KiB units) and `rd_len` = 64.
- R6: After the cycle of the third read handshake, `trn_en` stays high for exactly 200 more cycles with no read request, and then falls.
- R7: `calc_req` and `lane_ready` rise in the cycle in which `trn_en` falls, and never while `trn_en` is high. Lane delays are taken on each `lane_valid` cycle until a lane flagged with `lane_last`.
- R8: After the last lane, `ml_valid` is high with `ml_dly` equal to the unsigned maximum of the lane delays accepted in this pass. Both hold until `ml_ready`.
- R9: In the cycle after the max-latency handshake, `done` pulses for one cycle and `busy` is low. A start raised while busy has no effect on the pass, including its DIMM selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to begin a training pass |
| dimm_idx | input | DIMM_W | DIMM to train |
| refresh_off | input | 1 | Auto refresh is disabled |
| zqcal_off | input | 1 | ZQ calibration is disabled |
| busy | output | 1 | A pass is running |
| done | output | 1 | One-cycle end-of-pass pulse |
| dimm_sel | output | DIMM_W | DIMM select toward the PHY |
| cs_num | output | DIMM_W+1 | Chip select of the trained rank |
| seed_req | output | 1 | Request seed programming of all lanes |
| seed_ack | input | 1 | Seed programming finished |
| trn_en | output | 1 | Training-enable control |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | ADDR_W | Test address in 64 KiB units |
| rd_len | output | LEN_W | Read burst length in bytes |
| calc_req | output | 1 | Request final delay computation |
| lane_valid | input | 1 | Lane delay valid |
| lane_ready | output | 1 | Lane delay accepted |
| lane_dly | input | DLY_W | Final receiver-enable delay of one lane |
| lane_last | input | 1 | Marks the last lane |
| ml_valid | output | 1 | Maximum delay valid |
| ml_ready | input | 1 | Maximum delay accepted |
| ml_dly | output | DLY_W | Largest lane delay of the pass |

## Verification
The bench stalls the read port every other cycle or more. A design that dropped `rd_valid` under stall, or counted unacknowledged requests, would issue the wrong number of reads. The bench also checks the settle window to the exact cycle after the third acknowledge. An off-by-one counter would show up as `trn_en` falling one cycle early or late, together with a misplaced `calc_req`.

Lane streams come with gaps, with the maximum on the first lane, on the last lane, and with all lanes zero. This exposes a tracker that is not cleared between passes, or one that compares signed values. Starts are also raised while the block is busy and while refresh or ZQ calibration is still enabled. A design that accepted either would corrupt `dimm_sel` or raise `busy`.

// File: rtl/rxt_pkg.sv
package rxt_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SEED,
    PH_READ,
    PH_SETTLE,
    PH_CALC,
    PH_MAXLAT
  } rxt_phase_e;
endpackage

// File: rtl/rxt_step_cnt.sv
// Event counter that flags the event that reaches LIMIT.
module rxt_step_cnt #(
  parameter int LIMIT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic hit
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (clr)  cnt_q <= '0;
    else if (inc)  cnt_q <= cnt_q + 1'b1;
  end

  assign hit = inc && (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/rxt_max_track.sv
// Running unsigned maximum over a stream of values.
module rxt_max_track #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         upd,
  input  logic [W-1:0] din,
  output logic [W-1:0] max_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   max_o <= '0;
    else if (clr)                 max_o <= '0;
    else if (upd && din > max_o)  max_o <= din;
  end
endmodule

// File: rtl/rxt_fsm.sv
module rxt_fsm
  import rxt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_ok,
  input  logic       seed_ack,
  input  logic       rd_last,
  input  logic       settle_done,
  input  logic       lane_hs,
  input  logic       lane_last,
  input  logic       ml_ready,
  output rxt_phase_e phase,
  output logic       done
);
  rxt_phase_e nxt;

  always_comb begin
    nxt = phase;
    unique case (phase)
      PH_IDLE:   if (start_ok)              nxt = PH_SEED;
      PH_SEED:   if (seed_ack)              nxt = PH_READ;
      PH_READ:   if (rd_last)               nxt = PH_SETTLE;
      PH_SETTLE: if (settle_done)           nxt = PH_CALC;
      PH_CALC:   if (lane_hs && lane_last)  nxt = PH_MAXLAT;
      PH_MAXLAT: if (ml_ready)              nxt = PH_IDLE;
      default:                              nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      done  <= 1'b0;
    end else begin
      phase <= nxt;
      done  <= (phase == PH_MAXLAT) && ml_ready;
    end
  end
endmodule

// File: rtl/rxen_train_seq.sv
module rxen_train_seq
  import rxt_pkg::*;
#(
  parameter int          DIMM_W        = 2,
  parameter int          NUM_READS     = 3,
  parameter int          SETTLE_CYCLES = 200,
  parameter int          ADDR_W        = 24,
  parameter int          LEN_W         = 8,
  parameter int          BURST_BYTES   = 64,
  parameter int          TEST_ADDR_BIT = 21,
  parameter int          DLY_W         = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DIMM_W-1:0] dimm_idx,
  input  logic              refresh_off,
  input  logic              zqcal_off,
  output logic              busy,
  output logic              done,
  output logic [DIMM_W-1:0] dimm_sel,
  output logic [DIMM_W:0]   cs_num,
  output logic              seed_req,
  input  logic              seed_ack,
  output logic              trn_en,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [LEN_W-1:0]  rd_len,
  output logic              calc_req,
  input  logic              lane_valid,
  output logic              lane_ready,
  input  logic [DLY_W-1:0]  lane_dly,
  input  logic              lane_last,
  output logic              ml_valid,
  input  logic              ml_ready,
  output logic [DLY_W-1:0]  ml_dly
);
  localparam logic [ADDR_W-1:0] TEST_ADDR = ADDR_W'(1) << TEST_ADDR_BIT;

  rxt_phase_e        phase;
  logic              start_ok, rd_hs, rd_last, settle_done, lane_hs;
  logic [DIMM_W-1:0] dimm_q;

  assign start_ok = (phase == PH_IDLE) && start && refresh_off && zqcal_off;
  assign rd_hs    = rd_valid && rd_ready;
  assign lane_hs  = lane_valid && lane_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        dimm_q <= '0;
    else if (start_ok) dimm_q <= dimm_idx;
  end

  rxt_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start_ok(start_ok), .seed_ack(seed_ack),
    .rd_last(rd_last), .settle_done(settle_done), .lane_hs(lane_hs),
    .lane_last(lane_last), .ml_ready(ml_ready), .phase(phase), .done(done)
  );

  rxt_step_cnt #(.LIMIT(NUM_READS)) u_rd_cnt (
    .clk(clk), .rst_n(rst_n), .clr(start_ok), .inc(rd_hs), .hit(rd_last)
  );

  rxt_step_cnt #(.LIMIT(SETTLE_CYCLES)) u_settle_cnt (
    .clk(clk), .rst_n(rst_n), .clr(phase == PH_READ),
    .inc(phase == PH_SETTLE), .hit(settle_done)
  );

  rxt_max_track #(.W(DLY_W)) u_max (
    .clk(clk), .rst_n(rst_n), .clr(start_ok), .upd(lane_hs),
    .din(lane_dly), .max_o(ml_dly)
  );

  assign busy       = (phase != PH_IDLE);
  assign dimm_sel   = dimm_q;
  assign cs_num     = {dimm_q, 1'b0};
  assign seed_req   = (phase == PH_SEED);
  assign trn_en     = (phase == PH_READ) || (phase == PH_SETTLE);
  assign rd_valid   = (phase == PH_READ);
  assign rd_addr    = TEST_ADDR;
  assign rd_len     = LEN_W'(BURST_BYTES);
  assign calc_req   = (phase == PH_CALC);
  assign lane_ready = (phase == PH_CALC);
  assign ml_valid   = (phase == PH_MAXLAT);
endmodule

// File: rtl/rxt_sva.sv
module rxt_sva #(
  parameter int DIMM_W = 2,
  parameter int ADDR_W = 24,
  parameter int DLY_W  = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              refresh_off,
  input logic              zqcal_off,
  input logic              busy,
  input logic              done,
  input logic [DIMM_W-1:0] dimm_sel,
  input logic [DIMM_W:0]   cs_num,
  input logic              seed_req,
  input logic              trn_en,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              calc_req,
  input logic              ml_valid,
  input logic              ml_ready,
  input logic [DLY_W-1:0]  ml_dly
);
  // R1
  refused_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && !(refresh_off && zqcal_off)) |=> !busy);

  // R2
  dimm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(dimm_sel) && $stable(cs_num)));

  // R3
  seed_before_train_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seed_req |-> !trn_en);

  // R4
  read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));

  // R6
  read_in_train_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> trn_en);

  // R7
  calc_after_train_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trn_en) |-> calc_req);

  // R7
  calc_no_train_chk: assert property (@(posedge clk) disable iff (!rst_n)
    calc_req |-> !trn_en);

  // R8
  maxlat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ml_valid && !ml_ready) |=> (ml_valid && $stable(ml_dly)));

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind rxen_train_seq rxt_sva #(.DIMM_W(DIMM_W), .ADDR_W(ADDR_W), .DLY_W(DLY_W)) i_sva (
  .clk(clk), .rst_n(rst_n), .start(start), .refresh_off(refresh_off),
  .zqcal_off(zqcal_off), .busy(busy), .done(done), .dimm_sel(dimm_sel),
  .cs_num(cs_num), .seed_req(seed_req), .trn_en(trn_en), .rd_valid(rd_valid),
  .rd_ready(rd_ready), .rd_addr(rd_addr), .calc_req(calc_req),
  .ml_valid(ml_valid), .ml_ready(ml_ready), .ml_dly(ml_dly)
);

// File: tb/test_rxen_train_seq.sv
`timescale 1ns/1ps
module test_rxen_train_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic       start = 0, refresh_off = 1, zqcal_off = 1;
  logic [1:0] dimm_idx = 0;
  logic       busy, done, seed_req, trn_en, rd_valid, calc_req, lane_ready, ml_valid;
  logic [1:0] dimm_sel;
  logic [2:0] cs_num;
  logic [23:0] rd_addr;
  logic [7:0] rd_len;
  logic [9:0] ml_dly, lane_dly = 0;
  logic       seed_ack = 0, rd_ready = 0, lane_valid = 0, lane_last = 0, ml_ready = 0;

  rxen_train_seq i_rxen_train_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .dimm_idx(dimm_idx),
    .refresh_off(refresh_off), .zqcal_off(zqcal_off), .busy(busy), .done(done),
    .dimm_sel(dimm_sel), .cs_num(cs_num), .seed_req(seed_req), .seed_ack(seed_ack),
    .trn_en(trn_en), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rd_len(rd_len), .calc_req(calc_req), .lane_valid(lane_valid),
    .lane_ready(lane_ready), .lane_dly(lane_dly), .lane_last(lane_last),
    .ml_valid(ml_valid), .ml_ready(ml_ready), .ml_dly(ml_dly)
  );

  int vectors = 0, miscompares = 0, cyc = 0;

  task automatic chk(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // behavioural reference: phase 0 idle,1 seed,2 reads,3 settle,4 compute,5 offer max
  int m_ph = 0, m_dimm = 0, m_rd = 0, m_wait = 0, m_max = 0, m_done = 0;
  int lane_seq[$];
  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_dimm = 0; m_max = 0; m_done = 0;
    end else begin
      m_done = 0;
      case (m_ph)
        0: if (start && refresh_off && zqcal_off) begin
             m_ph = 1; m_dimm = dimm_idx; m_max = 0;
           end
        1: if (seed_ack) begin m_ph = 2; m_rd = 0; end
        2: if (rd_ready) begin
             m_rd++;
             if (m_rd == 3) begin m_ph = 3; m_wait = 0; end
           end
        3: begin m_wait++; if (m_wait == 200) m_ph = 4; end
        4: if (lane_valid) begin
             if (int'(lane_dly) > m_max) m_max = lane_dly;
             if (lane_last) m_ph = 5;
           end
        5: if (ml_ready) begin m_ph = 0; m_done = 1; end
        default: m_ph = 0;
      endcase
    end
  end

  // scenario knobs
  int seed_lat = 0, rd_bp = 0, lane_gap = 0, ml_lat = 0;
  int seed_w = 0, ml_w = 0, lane_idx = 0;
  logic [9:0] lanes [8];

  // compare on every clock, then drive responders (outputs depend on state only)
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk("R1", "busy", busy, m_ph != 0);
      chk("R2", "dimm_sel", dimm_sel, m_dimm);
      chk("R2", "cs_num", cs_num, m_dimm * 2);
      chk("R3", "seed_req", seed_req, m_ph == 1);
      chk("R4", "rd_valid", rd_valid, m_ph == 2);
      chk("R6", "trn_en", trn_en, (m_ph == 2) || (m_ph == 3));
      chk("R7", "calc_req", calc_req, m_ph == 4);
      chk("R7", "lane_ready", lane_ready, m_ph == 4);
      chk("R8", "ml_valid", ml_valid, m_ph == 5);
      if (m_ph == 5) chk("R8", "ml_dly", ml_dly, m_max);
      chk("R9", "done", done, m_done);
      if (rd_valid) begin
        chk("R5", "rd_addr", rd_addr, 24'h200000);
        chk("R5", "rd_len", rd_len, 64);
      end
    end
    // responders
    if (lane_valid && lane_ready) lane_idx++;
    if (!busy) lane_idx = 0;
    seed_w = seed_req ? seed_w + 1 : 0;
    seed_ack = seed_req && (seed_w > seed_lat);
    rd_ready = rd_valid && ((rd_bp == 0) || (cyc % 3 == 0));
    lane_valid = lane_ready && (lane_idx < 8) && ((lane_gap == 0) || cyc[0]);
    lane_dly = (lane_idx < 8) ? lanes[lane_idx] : 10'd0;
    lane_last = (lane_idx == 7);
    ml_w = ml_valid ? ml_w + 1 : 0;
    ml_ready = ml_valid && (ml_w > ml_lat);
    if (cyc > 100000) begin
      miscompares++;
      $display("FAIL watchdog expired: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic pulse_start(input int d, input bit ref_ok, input bit zq_ok);
    @(negedge clk);
    start = 1; dimm_idx = 2'(d); refresh_off = ref_ok; zqcal_off = zq_ok;
    @(negedge clk);
    start = 0; refresh_off = 1; zqcal_off = 1;
  endtask

  task automatic run_pass(input int d, input bit intrude);
    pulse_start(d, 1, 1);
    if (intrude) begin
      repeat (20) @(negedge clk);
      start = 1; dimm_idx = 2'(d + 1);   // R9: start while busy
      repeat (3) @(negedge clk);
      start = 0;
    end
    while (!done) @(negedge clk);
    chk("R9", "busy after done", busy, 0);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset busy", busy, 0);
    chk("R6", "reset trn_en", trn_en, 0);
    rst_n = 1;
    // R1: refused starts with refresh or ZQ calibration still active
    pulse_start(2, 0, 1);
    pulse_start(3, 1, 0);
    repeat (3) @(negedge clk);
    chk("R1", "refused start", busy, 0);
    // pass A: no back-pressure, max mid-stream
    foreach (lanes[i]) lanes[i] = 10'(10 + 37 * i);
    lanes[3] = 10'd1000;
    run_pass(1, 0);
    // pass B: stalled reads, gaps in lanes, max on last lane, slow handshakes
    foreach (lanes[i]) lanes[i] = 10'(5 * i);
    lanes[7] = 10'd777;
    seed_lat = 4; rd_bp = 1; lane_gap = 1; ml_lat = 3;
    run_pass(3, 1);
    // pass C: all zero lanes, max must not carry over
    foreach (lanes[i]) lanes[i] = 10'd0;
    seed_lat = 0; rd_bp = 1; lane_gap = 0; ml_lat = 0;
    run_pass(0, 0);
    // pass D: max on first lane, top value
    foreach (lanes[i]) lanes[i] = 10'(i);
    lanes[0] = 10'h3ff;
    rd_bp = 0; lane_gap = 1;
    run_pass(2, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule